// File: doc/BRIEF.md
# Flip-Flop Group Match and Gate Unit

This block keeps a bank of byte-wide flip-flop groups, a match register and a row of single-bit miscellaneous flip-flops. Each group has an upper half (the X half, bits 7:4) and a lower half (the Y half, bits 3:0). A four-bit command, applied with a source select, a destination select and a data byte, tells the block what to do. It can load a group or the match register, compare the match register with a source group, copy one group into another, set or clear a miscellaneous flip-flop, or read one back. A caller outside the block uses the one-bit decision to pick the next step. This block does not branch.

The block has three compare modes. Lower-to-lower compares the Y half of the match register with the Y half of the group. Cross-half compares the Y half of the match register with the X half of the group. Whole-word compares all eight bits. A compare returns 1 on a match and 0 on a mismatch. The decision output is registered two clock edges after the command and is flagged by a one-cycle valid pulse.

The group bank is a memory with one write port and one registered read port. Every state change takes effect at the second edge. Commands can be issued back to back, and each command sees the results of all commands issued before it.

Top module: `fgm_unit`

## Requirements
- R1: While reset is high, and at the first edge after it is released, `dec_o`, `dec_vld_o`, `grp_o` and `m_o` are all zero.
- R2: Command 3 (lower match) makes `dec_o` equal to 1 exactly when `m_o[3:0]` equals bits 3:0 of the group selected by `src_i`, and 0 otherwise.
- R3: Command 4 (cross match) makes `dec_o` equal to 1 exactly when `m_o[3:0]` equals bits 7:4 of the group selected by `src_i`, and 0 otherwise.
- R4: Command 5 (whole match) makes `dec_o` equal to 1 exactly when all 8 bits of `m_o` equal the group selected by `src_i`, and 0 otherwise.
- R5: Command 6 (gate) copies the group selected by `src_i` into the group selected by `dst_i`. The source group is not changed.
- R6: A gate whose source and destination select the same group leaves that group unchanged.
- R7: Command 8 clears and command 9 sets the miscellaneous flip-flop selected by `dst_i`. Command 7 returns the flip-flop selected by `src_i` on `dec_o`. All miscellaneous flip-flops reset to 0.
- R8: Command 1 loads `data_i` into the match register, which appears on `m_o`. Command 2 loads `data_i` into the group selected by `dst_i`. Command 10 puts the group selected by `src_i` on `grp_o`. `m_o` and `grp_o` keep their values under all other commands.
- R9: The outputs of a command appear after the second rising edge that follows the command. `dec_vld_o` is high for one cycle only after commands 3, 4, 5 and 7, and `dec_o` holds its value under every other command. Command 0 and codes 11 to 15 change no state.
- R10: When commands are issued on consecutive cycles, each command sees every group, match-register and flip-flop update made by the commands before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 4 | Command code |
| src_i | input | 4 | Source group or flip-flop select |
| dst_i | input | 4 | Destination group or flip-flop select |
| data_i | input | 8 | Load data |
| dec_o | output | 1 | Decision bit |
| dec_vld_o | output | 1 | Decision valid pulse |
| grp_o | output | 8 | Group read-out |
| m_o | output | 8 | Match register contents |

## Verification
The cross-half compare is the most likely to be wired wrongly. The bench loads groups whose X and Y halves differ and chooses match values that agree with only one half, so a design that compared the wrong half gives the opposite decision. Back-to-back streams include a gate, or a load, followed at once by a read or compare of the group just written. A design without the read-during-write bypass would return the old contents. The bench also runs gates with source equal to destination, repeated misc writes, and runs of idle commands between decisions. These catch a design that corrupts a group on a self-gate, drops a flip-flop write, or leaves the valid flag high or lets the decision drift.

// File: rtl/fgm_pkg.sv
package fgm_pkg;

  typedef enum logic [3:0] {
    OP_IDLE  = 4'd0,
    OP_LDM   = 4'd1,
    OP_LDG   = 4'd2,
    OP_CMPLO = 4'd3,
    OP_CMPX  = 4'd4,
    OP_CMPW  = 4'd5,
    OP_GATE  = 4'd6,
    OP_FRD   = 4'd7,
    OP_FCLR  = 4'd8,
    OP_FSET  = 4'd9,
    OP_GRD   = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    CM_LOW   = 2'd0,
    CM_CROSS = 2'd1,
    CM_WHOLE = 2'd2
  } cmp_mode_e;

  function automatic logic op_is_decision(input logic [3:0] op);
    return (op == OP_CMPLO) || (op == OP_CMPX) || (op == OP_CMPW) ||
           (op == OP_FRD);
  endfunction

endpackage

// File: rtl/fgm_bank.sv
module fgm_bank #(
  parameter int SW = 4,
  parameter int GW = 8,
  localparam int NG = 1 << SW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [GW-1:0] wdata,
  input  logic [SW-1:0] raddr,
  output logic [GW-1:0] rdata
);

  logic [GW-1:0] mem [NG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fgm_match.sv
module fgm_match #(
  parameter int GW = 8,
  localparam int HW = GW / 2
) (
  input  fgm_pkg::cmp_mode_e mode,
  input  logic [GW-1:0]      mreg,
  input  logic [GW-1:0]      grp,
  output logic               hit
);
  import fgm_pkg::*;

  logic lo_eq, cross_eq, whole_eq;

  assign lo_eq    = (mreg[HW-1:0] == grp[HW-1:0]);
  assign cross_eq = (mreg[HW-1:0] == grp[GW-1:HW]);
  assign whole_eq = (mreg == grp);

  always_comb begin
    unique case (mode)
      CM_LOW:   hit = lo_eq;
      CM_CROSS: hit = cross_eq;
      CM_WHOLE: hit = whole_eq;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/fgm_misc.sv
module fgm_misc #(
  parameter int SW = 4,
  localparam int NM = 1 << SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic          wval,
  input  logic [SW-1:0] rsel,
  output logic          rbit
);

  logic [NM-1:0] ff_q;

  always_ff @(posedge clk) begin
    if (rst)     ff_q <= '0;
    else if (we) ff_q[wsel] <= wval;
  end

  assign rbit = ff_q[rsel];

  AST_MISC_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |=> (ff_q[$past(wsel)] == $past(wval))); // R7

endmodule

// File: rtl/fgm_unit.sv
module fgm_unit #(
  parameter int SW = 4,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    cmd_i,
  input  logic [SW-1:0] src_i,
  input  logic [SW-1:0] dst_i,
  input  logic [GW-1:0] data_i,
  output logic          dec_o,
  output logic          dec_vld_o,
  output logic [GW-1:0] grp_o,
  output logic [GW-1:0] m_o
);
  import fgm_pkg::*;

  // stage 1 registers
  logic [3:0]    s1_op;
  logic [SW-1:0] s1_src, s1_dst;
  logic [GW-1:0] s1_data;
  logic          fwd_hit;
  logic [GW-1:0] fwd_data;

  // stage 2 signals
  logic [GW-1:0] bank_rd, opnd, wr_data;
  logic          wr_en, hit, fbit, dec_next, f_we;
  cmp_mode_e     mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op   <= OP_IDLE;
      s1_src  <= '0;
      s1_dst  <= '0;
      s1_data <= '0;
    end else begin
      s1_op   <= cmd_i;
      s1_src  <= src_i;
      s1_dst  <= dst_i;
      s1_data <= data_i;
    end
  end

  fgm_bank #(.SW(SW), .GW(GW)) u_bank (
    .clk   (clk),
    .we    (wr_en),
    .waddr (s1_dst),
    .wdata (wr_data),
    .raddr (src_i),
    .rdata (bank_rd)
  );

  // bypass for a read that meets a write at the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit  <= 1'b0;
      fwd_data <= '0;
    end else begin
      fwd_hit  <= wr_en && (s1_dst == src_i);
      fwd_data <= wr_data;
    end
  end

  assign opnd    = fwd_hit ? fwd_data : bank_rd;
  assign wr_en   = (s1_op == OP_LDG) || (s1_op == OP_GATE);
  assign wr_data = (s1_op == OP_LDG) ? s1_data : opnd;

  always_comb begin
    unique case (s1_op)
      OP_CMPX: mode = CM_CROSS;
      OP_CMPW: mode = CM_WHOLE;
      default: mode = CM_LOW;
    endcase
  end

  fgm_match #(.GW(GW)) u_match (
    .mode (mode),
    .mreg (m_o),
    .grp  (opnd),
    .hit  (hit)
  );

  assign f_we = (s1_op == OP_FCLR) || (s1_op == OP_FSET);

  fgm_misc #(.SW(SW)) u_misc (
    .clk  (clk),
    .rst  (rst),
    .we   (f_we),
    .wsel (s1_dst),
    .wval (s1_op == OP_FSET),
    .rsel (s1_src),
    .rbit (fbit)
  );

  assign dec_next = (s1_op == OP_FRD) ? fbit : hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_o     <= 1'b0;
      dec_vld_o <= 1'b0;
      grp_o     <= '0;
      m_o       <= '0;
    end else begin
      dec_vld_o <= op_is_decision(s1_op);
      if (op_is_decision(s1_op)) dec_o <= dec_next;
      if (s1_op == OP_GRD)       grp_o <= opnd;
      if (s1_op == OP_LDM)       m_o   <= s1_data;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dec_vld_o && !dec_o && grp_o == '0 && m_o == '0)); // R1
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
    op_is_decision(s1_op) |=> dec_vld_o); // R9
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_is_decision(s1_op) |=> (!dec_vld_o && $stable(dec_o))); // R9
  AST_M_HOLD: assert property (@(posedge clk) disable iff (rst)
    (s1_op != OP_LDM) |=> $stable(m_o)); // R8
  AST_GRP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (s1_op != OP_GRD) |=> $stable(grp_o)); // R8
  AST_LDM_TAKES: assert property (@(posedge clk) disable iff (rst)
    (s1_op == OP_LDM) |=> (m_o == $past(s1_data))); // R8

endmodule

// File: tb/fgm_unit_test.sv
module fgm_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cmd = 4'd0, src = 4'd0, dst = 4'd0;
  logic [7:0] data = 8'd0;
  logic       dec_o, dec_vld_o;
  logic [7:0] grp_o, m_o;

  always #2.5 clk = ~clk;

  fgm_unit uut (
    .clk(clk), .rst(rst), .cmd_i(cmd), .src_i(src), .dst_i(dst),
    .data_i(data), .dec_o(dec_o), .dec_vld_o(dec_vld_o),
    .grp_o(grp_o), .m_o(m_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [7:0] mg [16];
  logic [15:0] mf;
  logic [7:0] e_m, e_grp;
  logic       e_dec;

  // two-deep pipeline of expectations
  bit         p_act [2];
  logic       p_dec [2], p_vld [2];
  logic [7:0] p_grp [2], p_m [2];
  string      p_req [2];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic f_match(input logic [3:0] op, input logic [7:0] m,
                                   input logic [7:0] g);
    case (op)
      4'd3:    return m[3:0] == g[3:0];
      4'd4:    return m[3:0] == g[7:4];
      default: return m == g;
    endcase
  endfunction

  task automatic step(input logic [3:0] c, input logic [3:0] s,
                      input logic [3:0] d, input logic [7:0] x,
                      input string req);
    logic vld;
    @(negedge clk);
    if (p_act[1]) begin
      chk(dec_vld_o === p_vld[1], p_req[1], "dec_vld", {7'd0, dec_vld_o}, {7'd0, p_vld[1]});
      chk(dec_o === p_dec[1], p_req[1], "dec", {7'd0, dec_o}, {7'd0, p_dec[1]});
      chk(grp_o === p_grp[1], p_req[1], "grp", grp_o, p_grp[1]);
      chk(m_o === p_m[1], p_req[1], "m", m_o, p_m[1]);
    end
    p_act[1] = p_act[0]; p_dec[1] = p_dec[0]; p_vld[1] = p_vld[0];
    p_grp[1] = p_grp[0]; p_m[1] = p_m[0]; p_req[1] = p_req[0];
    cmd = c; src = s; dst = d; data = x;
    vld = 1'b0;
    case (c)
      4'd1: e_m = x;
      4'd2: mg[d] = x;
      4'd3, 4'd4, 4'd5: begin e_dec = f_match(c, e_m, mg[s]); vld = 1'b1; end
      4'd6: mg[d] = mg[s];
      4'd7: begin e_dec = mf[s]; vld = 1'b1; end
      4'd8: mf[d] = 1'b0;
      4'd9: mf[d] = 1'b1;
      4'd10: e_grp = mg[s];
      default: ;
    endcase
    p_act[0] = 1'b1; p_dec[0] = e_dec; p_vld[0] = vld;
    p_grp[0] = e_grp; p_m[0] = e_m; p_req[0] = req;
  endtask

  task automatic flush();
    repeat (2) step(4'd0, 4'd0, 4'd0, 8'd0, "R9");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    mf = '0; e_m = '0; e_grp = '0; e_dec = 1'b0;
    p_act[0] = 1'b0; p_act[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk(dec_o === 1'b0 && dec_vld_o === 1'b0, "R1", "dec in reset", {6'd0, dec_o, dec_vld_o}, 8'd0);
    chk(grp_o === 8'd0, "R1", "grp in reset", grp_o, 8'd0);
    chk(m_o === 8'd0, "R1", "m in reset", m_o, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(dec_vld_o === 1'b0 && m_o === 8'd0, "R1", "after release", m_o, 8'd0);
    // misc flip-flops start cleared
    for (int i = 0; i < 16; i++) step(4'd7, i[3:0], 4'd0, 8'd0, "R1");
    // load every group with distinct halves
    for (int i = 0; i < 16; i++) step(4'd2, 4'd0, i[3:0], {i[3:0], ~i[3:0]}, "R8");
    for (int i = 0; i < 16; i++) step(4'd10, i[3:0], 4'd0, 8'd0, "R8");
    // directed compares
    step(4'd1, 0, 0, 8'h0A, "R8");
    step(4'd3, 4'd5, 0, 0, "R2");   // group 5 = 5A, low match
    step(4'd4, 4'd5, 0, 0, "R3");   // cross: A vs 5 mismatch
    step(4'd4, 4'd10, 0, 0, "R3");  // group 10 = A5, cross match
    step(4'd3, 4'd10, 0, 0, "R2");  // low: A vs 5 mismatch
    step(4'd5, 4'd5, 0, 0, "R4");   // 0A vs 5A mismatch
    step(4'd1, 0, 0, 8'h5A, "R8");
    step(4'd5, 4'd5, 0, 0, "R4");   // whole match
    // gate then immediate use (bypass)
    step(4'd6, 4'd3, 4'd7, 0, "R5");
    step(4'd10, 4'd7, 0, 0, "R10");
    step(4'd10, 4'd3, 0, 0, "R5");
    step(4'd6, 4'd9, 4'd9, 0, "R6");
    step(4'd10, 4'd9, 0, 0, "R6");
    step(4'd2, 0, 4'd4, 8'h5A, "R8");
    step(4'd5, 4'd4, 0, 0, "R10");
    // misc
    step(4'd9, 0, 4'd15, 0, "R7");
    step(4'd7, 4'd15, 0, 0, "R7");
    step(4'd8, 0, 4'd15, 0, "R7");
    step(4'd7, 4'd15, 0, 0, "R7");
    step(4'd13, 4'd1, 4'd2, 8'hFF, "R9");
    flush();
    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] c, s, d;
      logic [7:0] x;
      string r;
      c = 4'($urandom_range(0, 15));
      s = 4'($urandom_range(0, 3));
      if ($urandom_range(0, 1)) s = 4'($urandom);
      d = ($urandom_range(0, 5) == 0) ? s : 4'($urandom_range(0, 3));
      x = 8'($urandom);
      if (c == 4'd1 && $urandom_range(0, 1)) x = mg[s];
      if (c == 4'd1 && $urandom_range(0, 2) == 0) x = {4'($urandom), mg[s][7:4]};
      case (c)
        4'd1, 4'd2, 4'd10: r = "R8";
        4'd3: r = "R2";
        4'd4: r = "R3";
        4'd5: r = "R4";
        4'd6: r = (s == d) ? "R6" : "R5";
        4'd7, 4'd8, 4'd9: r = "R7";
        default: r = "R9";
      endcase
      if (k % 7 == 3) r = "R10";
      step(c, s, d, x, r);
    end
    flush();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule